// File: doc/BRIEF.md
# Per-Pin Selectable Debounce Filter

This block sits between the input synchronisers and the interrupt detector. For each of the lowest-numbered pins it can require the synchronised level to stay at a new value for a chosen time before the change is passed on. A short glitch is therefore never seen downstream. The remaining pins, pins whose filter is disabled, and pins configured as edge-sensitive are passed through unchanged.

Each pin owns one byte of a 32-bit control word, so four pins share a word. Software reaches these bytes through three address views. One view returns the current settings. A second sets every bit written as 1. A third clears every bit written as 1. A shared prescaler divides the reference clock into half-millisecond ticks. Each filtered pin counts those ticks while its input disagrees with its filtered output.

Top module: `pinDebounce`

## Requirements
- R1: Pin n's control byte lives in word index n/4, at bit offset (n mod 4)*8. Within the byte, bit 0 is the enable and bits 6:4 are the time select. A read with address bits 11:8 equal to 5 returns the word picked by address bits 7:2. The other bits of the byte read 0, and a read at any other view returns 0.
- R2: A write with address bits 11:8 equal to 6 sets every enable or select bit written as 1. A write at view 7 clears every such bit written as 1. A write at view 5 changes nothing.
- R3: Bit 1 of a pin's byte is a counter restart. Writing it as 1 through view 6 restarts that pin's count within two clock cycles. It clears itself after one cycle and always reads back 0.
- R4: Select codes 0 to 6 give 1, 2, 32, 64, 128, 256 and 512 ticks (0.5, 1, 16, 32, 64, 128 and 256 ms). Code 7 gives 512 ticks. A tick lasts REF_HZ/2000 clock cycles.
- R5: On an active pin, the filtered output takes a new input value only after that value has held for the selected number of ticks. It does not change within (N-1) tick periods of the input change, and it has changed by N tick periods. A return of the input before then leaves the output unchanged and restarts the count.
- R6: Pins with index at or above DB_PINS have no control byte. Their bytes read 0, writes to them are ignored, and their output follows the input directly.
- R7: A pin whose levelSens input is 0 (edge-sensitive) passes its input straight to its output, even when its enable is set.
- R8: A pin whose enable is 0 passes its input straight to its output.
- R9: After reset every control byte reads 0 and every output follows its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address: bits 11:8 select the view, bits 7:2 select the word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| pinLevel | input | NUM_PINS | Synchronised pin levels |
| levelSens | input | NUM_PINS | 1 = pin is level-sensitive |
| filtLevel | output | NUM_PINS | Filtered pin levels |

## Verification
The hardest case to reach is a counter restart that lands in the middle of a count. The stimulus moves a pin's input, waits part of the window, and then writes the restart bit. It then checks that the output still holds past the point where an undisturbed count would have finished, and that the output moves one full window after the restart. The free-running prescaler makes the exact tick phase unknown to the bench. Each timing check therefore samples once at the last cycle where no change is allowed, and once at the first cycle where the change is guaranteed. The longest select codes are covered the same way.

// File: rtl/pinDebouncePkg.sv
package pinDebouncePkg;
  localparam int SEL_W      = 3;
  localparam int CNT_W      = 10;
  localparam int WORD_IDX_W = 6;
  localparam int LANES      = 4;

  typedef struct packed {
    logic                             tick;
    logic                             setOp;
    logic                             clrOp;
    logic [WORD_IDX_W-1:0]            wordSel;
    logic [LANES-1:0]                 enBits;
    logic [LANES-1:0]                 rstBits;
    logic [LANES-1:0][SEL_W-1:0]      selBits;
  } dbStrobe_t;

  // ticks of half a millisecond for each select code
  function automatic logic [CNT_W-1:0] selTicks(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] t;
    case (code)
      3'd0:    t = CNT_W'(1);
      3'd1:    t = CNT_W'(2);
      3'd2:    t = CNT_W'(32);
      3'd3:    t = CNT_W'(64);
      3'd4:    t = CNT_W'(128);
      3'd5:    t = CNT_W'(256);
      default: t = CNT_W'(512);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/dbCtrl.sv
module dbCtrl
  import pinDebouncePkg::*;
#(
  parameter int REF_HZ    = 32000,
  parameter int NUM_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [11:0]             regAddr,
  input  logic [31:0]             regWrData,
  input  logic [NUM_WORDS*32-1:0] fieldWords,
  output dbStrobe_t               strobes,
  output logic [31:0]             regRdData
);
  localparam int TICK_DIV = REF_HZ / 2000;
  localparam int PRE_W    = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] presc;
  logic             tickNow;
  logic [3:0]       view;
  logic             unusedBits;

  assign view    = regAddr[11:8];
  assign tickNow = (presc == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        presc <= '0;
    else if (tickNow) presc <= '0;
    else              presc <= presc + 1'b1;
  end

  always_comb begin
    strobes.tick    = tickNow;
    strobes.setOp   = regWrEn && (view == 4'h6);
    strobes.clrOp   = regWrEn && (view == 4'h7);
    strobes.wordSel = regAddr[7:2];
    for (int l = 0; l < LANES; l++) begin
      strobes.enBits[l]  = regWrData[l*8];
      strobes.rstBits[l] = regWrData[l*8+1];
      strobes.selBits[l] = regWrData[l*8+4 +: SEL_W];
    end
  end

  always_comb begin
    regRdData = '0;
    if (view == 4'h5) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regAddr[7:2] == WORD_IDX_W'(w)) regRdData = fieldWords[w*32 +: 32];
      end
    end
  end

  assign unusedBits = ^{regAddr[1:0], regWrData[31], regWrData[27:26],
                        regWrData[23], regWrData[19:18], regWrData[15],
                        regWrData[11:10], regWrData[7], regWrData[3:2]};
endmodule

// File: rtl/dbPath.sv
module dbPath
  import pinDebouncePkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int DB_PINS   = 6,
  parameter int NUM_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dbStrobe_t               strobes,
  input  logic [NUM_PINS-1:0]     pinLevel,
  input  logic [NUM_PINS-1:0]     levelSens,
  output logic [NUM_PINS-1:0]     filtLevel,
  output logic [NUM_PINS-1:0]     pinActive,
  output logic [NUM_WORDS*32-1:0] fieldWords
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    if (g < DB_PINS) begin : g_filt
      localparam int LANE = g % LANES;
      localparam logic [WORD_IDX_W-1:0] MY_WORD = WORD_IDX_W'(g / LANES);

      logic             en, rstPulse, state, hit, active;
      logic [SEL_W-1:0] sel;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W:0]   nextCnt;

      assign hit     = (strobes.wordSel == MY_WORD);
      assign active  = en && levelSens[g];
      assign nextCnt = {1'b0, cnt} + 1'b1;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          en       <= 1'b0;
          sel      <= '0;
          rstPulse <= 1'b0;
        end else begin
          rstPulse <= hit && strobes.setOp && strobes.rstBits[LANE];
          if (hit && strobes.setOp) begin
            en  <= en | strobes.enBits[LANE];
            sel <= sel | strobes.selBits[LANE];
          end else if (hit && strobes.clrOp) begin
            en  <= en & ~strobes.enBits[LANE];
            sel <= sel & ~strobes.selBits[LANE];
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          state <= 1'b0;
          cnt   <= '0;
        end else if (!active) begin
          state <= pinLevel[g];
          cnt   <= '0;
        end else if (rstPulse || (pinLevel[g] == state)) begin
          cnt <= '0;
        end else if (strobes.tick) begin
          if (nextCnt >= {1'b0, selTicks(sel)}) begin
            state <= pinLevel[g];
            cnt   <= '0;
          end else begin
            cnt <= nextCnt[CNT_W-1:0];
          end
        end
      end

      assign filtLevel[g]        = active ? state : pinLevel[g];
      assign pinActive[g]        = active;
      assign fieldWords[g*8 +: 8] = {1'b0, sel, 3'b000, en};
    end else begin : g_pass
      logic unusedSens;
      assign unusedSens           = levelSens[g];
      assign filtLevel[g]         = pinLevel[g];
      assign pinActive[g]         = 1'b0;
      assign fieldWords[g*8 +: 8] = 8'h00;
    end
  end

  if (NUM_WORDS * 32 > NUM_PINS * 8) begin : g_pad
    assign fieldWords[NUM_WORDS*32-1:NUM_PINS*8] = '0;
  end
endmodule

// File: rtl/pinDebounce.sv
module pinDebounce
  import pinDebouncePkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DB_PINS  = 6,
  parameter int REF_HZ   = 32000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [11:0]         regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] levelSens,
  output logic [NUM_PINS-1:0] filtLevel
);
  localparam int NUM_WORDS = (NUM_PINS + LANES - 1) / LANES;

  dbStrobe_t                strobes;
  logic [NUM_WORDS*32-1:0]  fieldWords;
  logic [NUM_PINS-1:0]      pinActive;

  dbCtrl #(.REF_HZ(REF_HZ), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .fieldWords(fieldWords), .strobes(strobes),
    .regRdData(regRdData)
  );

  dbPath #(.NUM_PINS(NUM_PINS), .DB_PINS(DB_PINS), .NUM_WORDS(NUM_WORDS)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pinLevel(pinLevel),
    .levelSens(levelSens), .filtLevel(filtLevel), .pinActive(pinActive),
    .fieldWords(fieldWords)
  );
endmodule

// File: rtl/pinDebounceChecker.sv
module pinDebounceChecker #(
  parameter int NUM_PINS = 8,
  parameter int DB_PINS  = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic [NUM_PINS-1:0] levelSens,
  input logic [NUM_PINS-1:0] filtLevel,
  input logic [NUM_PINS-1:0] pinActive,
  input logic [31:0]         regRdData
);
  assert_restart_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & 32'h0202_0202) == 32'h0);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    assert_edge_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
      !levelSens[g] |-> (filtLevel[g] == pinLevel[g]));

    assert_new_value_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(pinActive[g]) && pinActive[g] && (filtLevel[g] != $past(filtLevel[g])))
        |-> (filtLevel[g] == $past(pinLevel[g])));

    assert_hold_when_equal_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(pinActive[g]) && pinActive[g] && ($past(pinLevel[g]) == $past(filtLevel[g])))
        |-> $stable(filtLevel[g]));

    if (g >= DB_PINS) begin : g_out
      assert_out_of_range_R6: assert property (@(posedge clk) disable iff (!rstN)
        (filtLevel[g] == pinLevel[g]) && !pinActive[g]);
    end
  end
endmodule

bind pinDebounce pinDebounceChecker #(.NUM_PINS(NUM_PINS), .DB_PINS(DB_PINS)) u_check (
  .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .levelSens(levelSens),
  .filtLevel(filtLevel), .pinActive(pinActive), .regRdData(regRdData)
);

// File: tb/pinDebounce_bench.sv
`timescale 1ns/1ps
module pinDebounce_bench;
  localparam int NUM_PINS = 8;
  localparam int DB_PINS  = 6;
  localparam int T        = 16;   // cycles per tick at REF_HZ = 32000

  typedef struct packed {
    logic [11:0] wAddr;
    logic [31:0] wData;
    logic [11:0] rAddr;
    logic [31:0] expRd;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{12'h600, 32'hFFFF_FFFF, 12'h500, 32'h7171_7171},
    '{12'h700, 32'h0000_00F0, 12'h500, 32'h7171_7101},
    '{12'h604, 32'hFFFF_FFFF, 12'h504, 32'h0000_7171},
    '{12'h500, 32'h0000_0000, 12'h500, 32'h7171_7101},
    '{12'h700, 32'hFFFF_FFFF, 12'h500, 32'h0000_0000},
    '{12'h704, 32'h0000_0071, 12'h504, 32'h0000_7100},
    '{12'h600, 32'h0000_2300, 12'h500, 32'h0000_2100},
    '{12'h704, 32'hFFFF_FFFF, 12'h504, 32'h0000_0000},
    '{12'h700, 32'hFFFF_FFFF, 12'h500, 32'h0000_0000},
    '{12'h600, 32'h0000_0001, 12'h600, 32'h0000_0000}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                regWrEn = 1'b0;
  logic [11:0]         regAddr = '0;
  logic [31:0]         regWrData = '0;
  logic [31:0]         regRdData;
  logic [NUM_PINS-1:0] pinLevel = '0;
  logic [NUM_PINS-1:0] levelSens = '0;
  logic [NUM_PINS-1:0] filtLevel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pinDebounce #(.NUM_PINS(NUM_PINS), .DB_PINS(DB_PINS), .REF_HZ(32000)) u_pinDebounce (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinLevel(pinLevel),
    .levelSens(levelSens), .filtLevel(filtLevel)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; one rising edge latches the write
  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    pinLevel = 8'hA5;
    stepN(3);
    rstN = 1'b1;
    stepN(2);

    // R9 reset state
    regRead(12'h500, rd); checkEq("R9 word0 after reset", rd, 32'h0);
    regRead(12'h504, rd); checkEq("R9 word1 after reset", rd, 32'h0);
    checkEq("R9 outputs follow inputs", {24'h0, filtLevel}, 32'h0000_00A5);

    // R1 R2 R3 R6 register views, table driven
    foreach (VECS[i]) begin
      regWrite(VECS[i].wAddr, VECS[i].wData);
      regRead(VECS[i].rAddr, rd);
      checkEq($sformatf("R1 R2 R6 vector %0d", i), rd, VECS[i].expRd);
    end
    regWrite(12'h700, 32'hFFFF_FFFF);

    // R8 disabled pins follow the input directly
    levelSens = 8'hFF;
    stepN(1);
    pinLevel = 8'h3C; #0.5;
    checkEq("R8 disabled pins pass through", {24'h0, filtLevel}, 32'h0000_003C);
    stepN(1);
    pinLevel = 8'h00;
    stepN(2);

    // R4 R5 code 1 on pin 0: two ticks
    regWrite(12'h600, 32'h0000_0011);
    pinLevel[0] = 1'b1;
    stepN(T);
    checkEq("R5 code1 hold before window", {31'h0, filtLevel[0]}, 32'h0);
    stepN(T);
    checkEq("R4 code1 change after 2 ticks", {31'h0, filtLevel[0]}, 32'h1);

    // R4 code 0: one tick
    regWrite(12'h700, 32'h0000_0070);
    pinLevel[0] = 1'b0; #0.5;
    checkEq("R5 code0 no immediate change", {31'h0, filtLevel[0]}, 32'h1);
    stepN(T);
    checkEq("R4 code0 change after 1 tick", {31'h0, filtLevel[0]}, 32'h0);

    // R5 glitch on pin 1 with code 2 (32 ticks)
    regWrite(12'h600, 32'h0000_2100);
    pinLevel[1] = 1'b1;
    stepN(100);
    pinLevel[1] = 1'b0;
    stepN(600);
    checkEq("R5 short pulse rejected", {31'h0, filtLevel[1]}, 32'h0);
    pinLevel[1] = 1'b1;
    stepN(31 * T);
    checkEq("R5 code2 hold before window", {31'h0, filtLevel[1]}, 32'h0);
    stepN(T);
    checkEq("R4 code2 change after 32 ticks", {31'h0, filtLevel[1]}, 32'h1);

    // R3 counter restart mid-count on pin 2, code 1
    regWrite(12'h600, 32'h0011_0000);
    pinLevel[2] = 1'b1;
    stepN(20);
    regWrite(12'h600, 32'h0002_0000);
    stepN(12);
    checkEq("R3 restart delays change", {31'h0, filtLevel[2]}, 32'h0);
    stepN(27);
    checkEq("R3 change after restarted window", {31'h0, filtLevel[2]}, 32'h1);
    regRead(12'h500, rd);
    checkEq("R3 restart bit reads zero", rd, 32'h0011_2101);

    // R4 code 7 on pin 3 behaves as 512 ticks
    regWrite(12'h600, 32'h7100_0000);
    pinLevel[3] = 1'b1;
    stepN(511 * T);
    checkEq("R4 code7 hold before window", {31'h0, filtLevel[3]}, 32'h0);
    stepN(T);
    checkEq("R4 code7 change after 512 ticks", {31'h0, filtLevel[3]}, 32'h1);

    // R4 code 6 on pin 4
    regWrite(12'h604, 32'h0000_0061);
    pinLevel[4] = 1'b1;
    stepN(511 * T);
    checkEq("R4 code6 hold before window", {31'h0, filtLevel[4]}, 32'h0);
    stepN(T);
    checkEq("R4 code6 change after 512 ticks", {31'h0, filtLevel[4]}, 32'h1);

    // R7 edge-sensitive pin 5 ignores its enable
    regWrite(12'h604, 32'h0000_1100);
    levelSens[5] = 1'b0;
    pinLevel[5] = 1'b1; #0.5;
    checkEq("R7 edge-sensitive passes through", {31'h0, filtLevel[5]}, 32'h1);
    stepN(1);

    // R6 pin 6 beyond debounce range
    regWrite(12'h604, 32'h00FF_0000);
    regRead(12'h504, rd);
    checkEq("R6 out-of-range byte reads zero", rd, 32'h0000_1161);
    pinLevel[6] = 1'b1; #0.5;
    checkEq("R6 out-of-range pin passes through", {31'h0, filtLevel[6]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule